// File: doc/BRIEF.md
# VGA Planar Read Unit

This block serves host reads from a four-plane VGA frame buffer. Each read brings in one 32-bit word, where each byte is one plane. The block stores that word in a display latch, so later write operations can use it. It also reduces the word to the single byte that the host receives.

The host byte is formed in one of two ways:

- **Plane-select mode:** one plane is picked, either from a map-select setting or from low host address bits when a chained addressing mode is on.
- **Compare mode:** every bit position is compared across the planes against a colour value. The result is a one-bit-per-pixel mask, and a care mask can leave planes out of the comparison.

Memory access and address decoding are done upstream. This block only sees the returned word and a flag that says whether the read targeted VGA space.

Top module: `vga_read_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0, `out_byte` is 0x00 and `latch_q` is 0.
- R2: A read is accepted when `rd_valid` and `rd_hit` are both 1. On the next rising edge, `latch_q` holds the full `rd_data` word and `out_valid` is 1 for one cycle. The byte is valid in that cycle.
- R3: When `rd_mode` is 0 and neither chained mode is on, `out_byte` is plane `map_sel`. Plane b is `rd_data[8b+7:8b]`.
- R4: When `chain4` is 1 in plane-select mode, `host_addr[1:0]` chooses the plane. This overrides both `map_sel` and `odd_even`.
- R5: When `odd_even` is 1 and `chain4` is 0 in plane-select mode, the plane index is {`map_sel[1]`, `host_addr[0]`}.
- R6: When `rd_mode` is 1, bit n of `out_byte` is 1 only if, for each plane b whose `cmp_care[b]` is 1, bit n of plane b equals `cmp_color[b]`.
- R7: A plane with `cmp_care[b]` equal to 0 is left out of the comparison. If `cmp_care` is 0, `out_byte` is 0xFF.
- R8: A cycle with no accepted read (`rd_hit` 0 or `rd_valid` 0) gives `out_valid` 0 on the next edge and leaves `latch_q` and `out_byte` unchanged.
- R9: The `rd_mode` encoding is 0 for plane select and 1 for colour compare. The mode is sampled with the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Frame-buffer read data present this cycle |
| rd_hit | input | 1 | The read targeted VGA space |
| rd_data | input | 32 | Frame-buffer word, plane b in byte b |
| host_addr | input | 2 | Low host address bits |
| chain4 | input | 1 | Four-way chained addressing enable |
| odd_even | input | 1 | Two-way chained addressing enable |
| map_sel | input | 2 | Plane chosen for plane-select reads |
| cmp_color | input | 4 | Colour compared, one bit per plane |
| cmp_care | input | 4 | Planes taking part in the compare (1 = included) |
| rd_mode | input | 1 | 0 plane select, 1 colour compare |
| out_byte | output | 8 | Byte returned to the host |
| out_valid | output | 1 | `out_byte` is fresh this cycle |
| latch_q | output | 32 | Display latch contents |

## Verification
The bench walks plane select through every plane index, and sets `map_sel` to a value that disagrees with the address. This catches a design that ignores the chained override.

It sets both chained flags together to check precedence. A design with the order reversed would return the odd/even plane instead.

Compare-mode patterns include mismatches confined to a single excluded plane. They also include an all-excluded care mask, where a wrong design returns 0x00 rather than 0xFF.

Missed reads carry a word different from the one held. A latch that loads on the data strobe alone would then show the new word on `latch_q`.

// File: rtl/vga_rd_pkg.sv
package vga_rd_pkg;
  typedef enum logic {
    RD_PLANE   = 1'b0,
    RD_COMPARE = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/vga_plane_pick.sv
module vga_plane_pick #(
  parameter int PLANES = 4,
  parameter int PW     = 8,
  localparam int SW    = $clog2(PLANES),
  localparam int WW    = PLANES * PW
) (
  input  logic [WW-1:0] word,
  input  logic [SW-1:0] addr,
  input  logic [SW-1:0] map_sel,
  input  logic          chain4,
  input  logic          odd_even,
  output logic [PW-1:0] plane_byte
);
  logic [SW-1:0] idx;

  always_comb begin
    if (chain4)
      idx = addr;
    else if (odd_even)
      idx = {map_sel[SW-1:1], addr[0]};
    else
      idx = map_sel;
  end

  assign plane_byte = word[idx*PW +: PW];
endmodule

// File: rtl/vga_color_match.sv
module vga_color_match #(
  parameter int PLANES = 4,
  parameter int PW     = 8,
  localparam int WW    = PLANES * PW
) (
  input  logic [WW-1:0]     word,
  input  logic [PLANES-1:0] color,
  input  logic [PLANES-1:0] care,
  output logic [PW-1:0]     match
);
  for (genvar n = 0; n < PW; n++) begin : g_bit
    always_comb begin
      match[n] = 1'b1;
      for (int b = 0; b < PLANES; b++) begin
        if (care[b] && (word[b*PW + n] != color[b]))
          match[n] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/vga_read_unit.sv
module vga_read_unit
  import vga_rd_pkg::*;
#(
  parameter int PLANES = 4,
  parameter int PW     = 8,
  localparam int SW    = $clog2(PLANES),
  localparam int WW    = PLANES * PW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic              rd_hit,
  input  logic [WW-1:0]     rd_data,
  input  logic [SW-1:0]     host_addr,
  input  logic              chain4,
  input  logic              odd_even,
  input  logic [SW-1:0]     map_sel,
  input  logic [PLANES-1:0] cmp_color,
  input  logic [PLANES-1:0] cmp_care,
  input  logic              rd_mode,
  output logic [PW-1:0]     out_byte,
  output logic              out_valid,
  output logic [WW-1:0]     latch_q
);
  logic          take;
  logic [PW-1:0] pick_byte;
  logic [PW-1:0] cmp_byte;
  logic [PW-1:0] next_byte;

  assign take = rd_valid && rd_hit;

  vga_plane_pick #(.PLANES(PLANES), .PW(PW)) u_pick (
    .word       (rd_data),
    .addr       (host_addr),
    .map_sel    (map_sel),
    .chain4     (chain4),
    .odd_even   (odd_even),
    .plane_byte (pick_byte)
  );

  vga_color_match #(.PLANES(PLANES), .PW(PW)) u_match (
    .word  (rd_data),
    .color (cmp_color),
    .care  (cmp_care),
    .match (cmp_byte)
  );

  assign next_byte = (rd_mode_e'(rd_mode) == RD_COMPARE) ? cmp_byte : pick_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_byte  <= '0;
      out_valid <= 1'b0;
      latch_q   <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_byte <= next_byte;
        latch_q  <= rd_data;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid); // R2
  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    take |=> latch_q == $past(rd_data)); // R2
  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take |=> !out_valid && $stable(latch_q) && $stable(out_byte)); // R8
  AST_ALL_EXCLUDED: assert property (@(posedge clk) disable iff (rst)
    (take && rd_mode && cmp_care == '0) |=> out_byte == {PW{1'b1}}); // R7
  AST_CHAIN4_PICK: assert property (@(posedge clk) disable iff (rst)
    (take && !rd_mode && chain4) |=>
      out_byte == PW'($past(rd_data) >> ($past(host_addr) * PW))); // R4
endmodule

// File: tb/sim_vga_read_unit.sv
module sim_vga_read_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        rd_valid, rd_hit, chain4, odd_even, rd_mode;
  logic [31:0] rd_data;
  logic [1:0]  host_addr, map_sel;
  logic [3:0]  cmp_color, cmp_care;
  logic [7:0]  out_byte;
  logic        out_valid;
  logic [31:0] latch_q;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  vga_read_unit u0 (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_hit(rd_hit),
    .rd_data(rd_data), .host_addr(host_addr), .chain4(chain4),
    .odd_even(odd_even), .map_sel(map_sel), .cmp_color(cmp_color),
    .cmp_care(cmp_care), .rd_mode(rd_mode), .out_byte(out_byte),
    .out_valid(out_valid), .latch_q(latch_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmp_ref(input logic [31:0] w, input logic [3:0] col,
                                          input logic [3:0] care);
    logic [7:0] r;
    for (int n = 0; n < 8; n++) begin
      r[n] = 1'b1;
      for (int b = 0; b < 4; b++)
        if (care[b] && w[b*8+n] != col[b]) r[n] = 1'b0;
    end
    return r;
  endfunction

  task automatic idle();
    @(negedge clk);
    rd_valid = 0; rd_hit = 0;
  endtask

  task automatic do_read(input logic [31:0] w, input logic hit, input logic [1:0] a,
                         input logic c4, input logic oe, input logic [1:0] ms,
                         input logic md, input logic [3:0] col, input logic [3:0] care);
    @(negedge clk);
    rd_valid = 1; rd_hit = hit; rd_data = w; host_addr = a; chain4 = c4;
    odd_even = oe; map_sel = ms; rd_mode = md; cmp_color = col; cmp_care = care;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst = 1; rd_valid = 0; rd_hit = 0; rd_data = '0; host_addr = 0; chain4 = 0;
    odd_even = 0; map_sel = 0; rd_mode = 0; cmp_color = 0; cmp_care = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    chk("R1 valid", {31'b0, out_valid}, 0);
    chk("R1 byte", {24'b0, out_byte}, 0);
    chk("R1 latch", latch_q, 0);
  endtask

  task automatic t_plane_select();
    logic [31:0] w = 32'hD4C3B2A1;
    for (int p = 0; p < 4; p++) begin
      do_read(w, 1, 2'(3 - p), 0, 0, 2'(p), 0, 0, 0);
      chk("R3 R9 plane byte", {24'b0, out_byte}, {24'b0, w[p*8 +: 8]});
      chk("R2 valid", {31'b0, out_valid}, 1);
      chk("R2 latch", latch_q, w);
    end
    idle();
  endtask

  task automatic t_chain4();
    logic [31:0] w = 32'h44332211;
    for (int a = 0; a < 4; a++) begin
      do_read(w, 1, 2'(a), 1, 1, 2'(a ^ 3), 0, 0, 0);
      chk("R4 chain4 addr pick", {24'b0, out_byte}, {24'b0, w[a*8 +: 8]});
    end
    idle();
  endtask

  task automatic t_odd_even();
    logic [31:0] w = 32'h8C7B6A59;
    do_read(w, 1, 2'b01, 0, 1, 2'b10, 0, 0, 0);
    chk("R5 odd/even idx3", {24'b0, out_byte}, {24'b0, w[31:24]});
    do_read(w, 1, 2'b10, 0, 1, 2'b01, 0, 0, 0);
    chk("R5 odd/even idx0", {24'b0, out_byte}, {24'b0, w[7:0]});
    idle();
  endtask

  task automatic t_compare();
    logic [31:0] w;
    w = 32'h0F33_55FF;
    do_read(w, 1, 0, 0, 0, 0, 1, 4'b0101, 4'b1111);
    chk("R6 compare full", {24'b0, out_byte}, {24'b0, cmp_ref(w, 4'b0101, 4'b1111)});
    w = 32'hF0F0_A5C3;
    do_read(w, 1, 0, 0, 0, 0, 1, 4'b1011, 4'b1111);
    chk("R6 compare mixed", {24'b0, out_byte}, {24'b0, cmp_ref(w, 4'b1011, 4'b1111)});
    w = 32'h00FF_FF12;
    do_read(w, 1, 0, 0, 0, 0, 1, 4'b0110, 4'b0110);
    chk("R7 excluded plane", {24'b0, out_byte}, 32'hFF);
    do_read(w, 1, 0, 0, 0, 0, 1, 4'b0000, 4'b0000);
    chk("R7 all excluded", {24'b0, out_byte}, 32'hFF);
    idle();
  endtask

  task automatic t_miss();
    logic [31:0] held = 32'h1357_9BDF;
    do_read(held, 1, 0, 0, 0, 2, 0, 0, 0);
    do_read(32'hCAFE_F00D, 0, 1, 0, 0, 1, 0, 0, 0);
    chk("R8 miss valid", {31'b0, out_valid}, 0);
    chk("R8 miss latch", latch_q, held);
    chk("R8 miss byte", {24'b0, out_byte}, {24'b0, held[23:16]});
    idle(); #1;
    chk("R2 valid one cycle", {31'b0, out_valid}, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_plane_select();
        t_chain4();
        t_odd_even();
        t_compare();
        t_miss();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule